// File: doc/BRIEF.md
# Change-of-flow program trace recorder

The recorder sits beside a processor core and watches its stream of retired-instruction events. Each event carries a 23-bit program address, a 4-bit instruction-class code and a flag that marks the address as an interrupt vector fetch. Only events that change program flow in a way a debugger cannot infer are kept:

- the source address of a taken conditional branch;
- the destination address of an indexed jump or call;
- the destination address of a return;
- the vector address of a qualifying interrupt.

Each kept event becomes one line in a 64-line circular buffer. A line holds the address and an information byte that tells source records from destination records.

Recording starts when the block is armed and ends according to one of two storage policies. Under the end-trigger policy, storing stops at the trigger and the block disarms; an event that arrives in the trigger cycle is dropped. Under the mid-trigger policy, a fixed number of further lines (32 by default) is stored after the trigger. The block then disarms and raises a one-cycle breakpoint request, so the break happens some way after the triggering instruction.

Once recording has ended, software-side logic reads the lines, oldest first, through an index-addressed port, using the valid-line count to know how many there are. A 2-bit mode input selects the trace mode. Only the change-of-flow mode (code 0) records anything.

Top module: `cof_trace_rec`

## Requirements
- R1: After reset, armed_o, done_o and brk_o are 0 and line_cnt_o is 0.
- R2: While armed in mode 0, a valid event of class 1 (taken conditional branch) stores one line. The line holds the event address, and its info bit 0 is 0 (source record).
- R3: Class 2 (indexed jump or call) and class 3 (return) events store their address with info bit 0 set to 1 (destination record) and info bit 1 set to 0.
- R4: A class 4 (interrupt) event with the vector flag at 1 stores its address with info bits 1 and 0 both at 1. Events of class 0, class 5 (excluded software or debug vector), classes 6 to 15, and class 4 with the vector flag at 0 store nothing.
- R5: At most one line is stored per valid cycle, and lines keep arrival order. A destination record followed in the next cycle by an interrupt vector event yields the destination line first.
- R6: The buffer holds 64 lines and wraps. line_cnt_o saturates at 64. Read index 0 always returns the oldest line held.
- R7: With policy_i=0 (end-trigger), a trigger while armed clears armed_o and sets done_o on the next cycle, and an event in the trigger cycle is not stored.
- R8: With policy_i=1 (mid-trigger), an event in the trigger cycle is stored. Exactly 32 further lines are then stored. In the cycle after the 32nd, armed_o is 0, done_o is 1 and brk_o is 1 for that one cycle only.
- R9: With mode_i other than 0, no event is stored while armed.
- R10: arm_i sets armed_o and clears line_cnt_o and done_o on the next cycle. An event in the arm cycle is not stored.
- R11: While not armed, no line is stored. While armed, or for a read index at or above line_cnt_o, rd_addr_o and rd_info_o read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Arm pulse; restarts recording |
| mode_i | input | 2 | Trace mode, 0 = change-of-flow |
| policy_i | input | 1 | 0 = end-trigger, 1 = mid-trigger |
| trig_i | input | 1 | Trigger from the comparators |
| evt_valid_i | input | 1 | Retired-instruction event valid |
| evt_addr_i | input | 23 | Event program address |
| evt_cls_i | input | 4 | Instruction-class code |
| evt_vec_i | input | 1 | Address is an interrupt vector |
| rd_idx_i | input | 6 | Read index, 0 = oldest line |
| rd_addr_o | output | 23 | Address of the line read |
| rd_info_o | output | 8 | Info byte of the line read |
| line_cnt_o | output | 7 | Valid-line count |
| armed_o | output | 1 | Recording is armed |
| done_o | output | 1 | Recording has ended |
| brk_o | output | 1 | Breakpoint request pulse |

## Verification
The bench feeds every class code with and without the vector flag. A wrong classifier shows up as stray lines, missing lines or a flipped source/destination bit.

Seventy events are written so the buffer wraps. A design that lets the count run on, or that reads from the physical slot instead of the oldest slot, returns the wrong address at index 0.

The end-trigger test places an event in the trigger cycle. A design that stores it ends one line long.

The mid-trigger test samples done_o after lines 31 and 32 and brk_o one cycle later. An off-by-one post counter, or a breakpoint level instead of a pulse, is caught.

Re-arming after a finished run, and non-zero modes, are each checked to leave the buffer empty.

// File: rtl/cof_trace_pkg.sv
package cof_trace_pkg;
  localparam int ADDR_W = 23;
  localparam int INFO_W = 8;

  typedef enum logic [3:0] {
    CLS_OTHER    = 4'd0,
    CLS_COND_TKN = 4'd1,
    CLS_IDX_JMP  = 4'd2,
    CLS_RETURN   = 4'd3,
    CLS_IRQ      = 4'd4,
    CLS_IRQ_EXCL = 4'd5
  } evt_cls_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [INFO_W-1:0] info;
  } trace_line_t;

  localparam int INFO_DST_BIT = 0;
  localparam int INFO_VEC_BIT = 1;
endpackage

// File: rtl/cof_trace_filter.sv
module cof_trace_filter
  import cof_trace_pkg::*;
(
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        cls_i,
  input  logic              vec_i,
  output logic              keep_o,
  output trace_line_t       line_o
);
  logic is_dst, is_vec, is_src;

  always_comb begin
    is_src = 1'b0;
    is_dst = 1'b0;
    is_vec = 1'b0;
    unique case (cls_i)
      CLS_COND_TKN: is_src = 1'b1;
      CLS_IDX_JMP,
      CLS_RETURN:   is_dst = 1'b1;
      CLS_IRQ: begin
        is_dst = vec_i;
        is_vec = vec_i;
      end
      default: ;
    endcase
  end

  assign keep_o = valid_i & (is_src | is_dst);

  always_comb begin
    line_o = '0;
    line_o.addr = addr_i;
    line_o.info[INFO_DST_BIT] = is_dst;
    line_o.info[INFO_VEC_BIT] = is_vec;
  end
endmodule

// File: rtl/cof_trace_ctrl.sv
module cof_trace_ctrl #(
  parameter int POST_LINES = 32,
  localparam int PCW = $clog2(POST_LINES + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       arm_i,
  input  logic [1:0] mode_i,
  input  logic       policy_i,
  input  logic       trig_i,
  input  logic       keep_i,
  output logic       wr_en_o,
  output logic       clr_o,
  output logic       armed_o,
  output logic       done_o,
  output logic       brk_o
);
  logic           trig_seen_q;
  logic [PCW-1:0] post_q;
  logic           end_stop;

  assign end_stop = trig_i & ~policy_i;
  assign clr_o    = arm_i;
  assign wr_en_o  = armed_o & ~arm_i & keep_i & (mode_i == 2'd0) & ~end_stop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_o     <= 1'b0;
      done_o      <= 1'b0;
      brk_o       <= 1'b0;
      trig_seen_q <= 1'b0;
      post_q      <= '0;
    end else if (arm_i) begin
      armed_o     <= 1'b1;
      done_o      <= 1'b0;
      brk_o       <= 1'b0;
      trig_seen_q <= 1'b0;
      post_q      <= '0;
    end else begin
      brk_o <= 1'b0;
      if (armed_o) begin
        if (!policy_i) begin
          if (trig_i) begin
            armed_o <= 1'b0;
            done_o  <= 1'b1;
          end
        end else if (!trig_seen_q) begin
          if (trig_i) trig_seen_q <= 1'b1;
        end else if (wr_en_o) begin
          // trigger-cycle line is not counted
          if (post_q == PCW'(POST_LINES - 1)) begin
            armed_o <= 1'b0;
            done_o  <= 1'b1;
            brk_o   <= 1'b1;
          end else begin
            post_q <= post_q + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/cof_trace_buf.sv
module cof_trace_buf
  import cof_trace_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = IW + 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        wr_en_i,
  input  trace_line_t wr_line_i,
  input  logic        rd_en_i,
  input  logic [IW-1:0] rd_idx_i,
  output trace_line_t rd_line_o,
  output logic [CW-1:0] cnt_o
);
  trace_line_t   mem_q [DEPTH];
  logic [IW-1:0] wptr_q;
  logic [IW-1:0] phys_idx;
  logic          full;

  assign full = (cnt_o == CW'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      cnt_o  <= '0;
    end else if (clr_i) begin
      wptr_q <= '0;
      cnt_o  <= '0;
    end else if (wr_en_i) begin
      wptr_q <= wptr_q + 1'b1;
      if (!full) cnt_o <= cnt_o + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i && !clr_i) mem_q[wptr_q] <= wr_line_i;
  end

  // once wrapped the oldest line sits at the write pointer
  assign phys_idx = full ? (wptr_q + rd_idx_i) : rd_idx_i;

  always_comb begin
    rd_line_o = '0;
    if (rd_en_i && (CW'(rd_idx_i) < cnt_o)) rd_line_o = mem_q[phys_idx];
  end
endmodule

// File: rtl/cof_trace_rec.sv
module cof_trace_rec
  import cof_trace_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int POST_LINES = 32,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = IW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic [1:0]        mode_i,
  input  logic              policy_i,
  input  logic              trig_i,
  input  logic              evt_valid_i,
  input  logic [ADDR_W-1:0] evt_addr_i,
  input  logic [3:0]        evt_cls_i,
  input  logic              evt_vec_i,
  input  logic [IW-1:0]     rd_idx_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [INFO_W-1:0] rd_info_o,
  output logic [CW-1:0]     line_cnt_o,
  output logic              armed_o,
  output logic              done_o,
  output logic              brk_o
);
  logic        keep, wr_en, clr;
  trace_line_t wr_line, rd_line;

  cof_trace_filter u_filter (
    .valid_i (evt_valid_i),
    .addr_i  (evt_addr_i),
    .cls_i   (evt_cls_i),
    .vec_i   (evt_vec_i),
    .keep_o  (keep),
    .line_o  (wr_line)
  );

  cof_trace_ctrl #(.POST_LINES(POST_LINES)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arm_i    (arm_i),
    .mode_i   (mode_i),
    .policy_i (policy_i),
    .trig_i   (trig_i),
    .keep_i   (keep),
    .wr_en_o  (wr_en),
    .clr_o    (clr),
    .armed_o  (armed_o),
    .done_o   (done_o),
    .brk_o    (brk_o)
  );

  cof_trace_buf #(.DEPTH(DEPTH)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .wr_en_i   (wr_en),
    .wr_line_i (wr_line),
    .rd_en_i   (~armed_o),
    .rd_idx_i  (rd_idx_i),
    .rd_line_o (rd_line),
    .cnt_o     (line_cnt_o)
  );

  assign rd_addr_o = rd_line.addr;
  assign rd_info_o = rd_line.info;
endmodule

// File: rtl/cof_trace_chk.sv
module cof_trace_chk #(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          arm_i,
  input logic [1:0]    mode_i,
  input logic          policy_i,
  input logic          trig_i,
  input logic [CW-1:0] line_cnt_o,
  input logic          armed_o,
  input logic          done_o,
  input logic          brk_o
);
  p_cnt_le_depth_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_cnt_o <= CW'(DEPTH));

  p_no_store_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_o && !arm_i) |=> $stable(line_cnt_o));

  p_end_trig_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_o && trig_i && !policy_i && !arm_i) |=> (!armed_o && done_o && $stable(line_cnt_o)));

  p_brk_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_o |=> !brk_o);

  p_brk_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_o |-> (done_o && !armed_o));

  p_mode_stub_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_o && mode_i != 2'd0 && !arm_i) |=> $stable(line_cnt_o));

  p_arm_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> (armed_o && !done_o && line_cnt_o == '0));
endmodule

bind cof_trace_rec cof_trace_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .arm_i      (arm_i),
  .mode_i     (mode_i),
  .policy_i   (policy_i),
  .trig_i     (trig_i),
  .line_cnt_o (line_cnt_o),
  .armed_o    (armed_o),
  .done_o     (done_o),
  .brk_o      (brk_o)
);

// File: tb/cof_trace_rec_bench.sv
`timescale 1ns/1ps
module cof_trace_rec_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arm = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        policy = 1'b0;
  logic        trig = 1'b0;
  logic        ev_v = 1'b0;
  logic [22:0] ev_a = '0;
  logic [3:0]  ev_c = '0;
  logic        ev_vec = 1'b0;
  logic [5:0]  rd_idx = '0;
  logic [22:0] rd_addr;
  logic [7:0]  rd_info;
  logic [6:0]  cnt;
  logic        armed, done, brk;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  cof_trace_rec u_cof_trace_rec (
    .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .mode_i(mode), .policy_i(policy),
    .trig_i(trig), .evt_valid_i(ev_v), .evt_addr_i(ev_a), .evt_cls_i(ev_c),
    .evt_vec_i(ev_vec), .rd_idx_i(rd_idx), .rd_addr_o(rd_addr), .rd_info_o(rd_info),
    .line_cnt_o(cnt), .armed_o(armed), .done_o(done), .brk_o(brk)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle with the given inputs, then idle; ends at a negedge
  task automatic cyc(input logic a, input logic t, input logic v,
                     input logic [3:0] c, input logic [22:0] ad, input logic vc);
    @(negedge clk);
    arm = a; trig = t; ev_v = v; ev_c = c; ev_a = ad; ev_vec = vc;
    @(negedge clk);
    arm = 0; trig = 0; ev_v = 0;
  endtask

  task automatic do_arm();
    cyc(1, 0, 0, 4'd0, '0, 0);
  endtask
  task automatic ev(input logic [3:0] c, input logic [22:0] ad, input logic vc);
    cyc(0, 0, 1, c, ad, vc);
  endtask
  task automatic stop();
    cyc(0, 1, 0, 4'd0, '0, 0);
  endtask

  task automatic rd_chk(input string req, input int idx, input logic [22:0] ea, input logic [7:0] ei);
    rd_idx = 6'(idx);
    #0.5;
    chk(req, {9'd0, rd_addr}, {9'd0, ea});
    chk(req, {24'd0, rd_info}, {24'd0, ei});
  endtask

  task automatic t_reset();
    chk("R1 armed", {31'd0, armed}, 0);
    chk("R1 done", {31'd0, done}, 0);
    chk("R1 brk", {31'd0, brk}, 0);
    chk("R1 cnt", {25'd0, cnt}, 0);
  endtask

  task automatic t_filter();
    policy = 0; mode = 0;
    do_arm();
    chk("R10 armed", {31'd0, armed}, 1);
    ev(4'd1, 23'h000101, 0);
    rd_chk("R11 read while armed", 0, 0, 0);
    ev(4'd0, 23'h000102, 0);
    ev(4'd2, 23'h000103, 0);
    ev(4'd3, 23'h000104, 0);
    ev(4'd4, 23'h000105, 1);
    ev(4'd4, 23'h000106, 0);
    ev(4'd5, 23'h000107, 1);
    ev(4'd9, 23'h000108, 0);
    ev(4'd15, 23'h000109, 1);
    stop();
    chk("R7 done", {31'd0, done}, 1);
    chk("R7 armed", {31'd0, armed}, 0);
    chk("R4 excluded classes cnt", {25'd0, cnt}, 4);
    rd_chk("R2 source line", 0, 23'h000101, 8'h00);
    rd_chk("R3 indexed jump dst", 1, 23'h000103, 8'h01);
    rd_chk("R3 return dst", 2, 23'h000104, 8'h01);
    rd_chk("R4 vector line", 3, 23'h000105, 8'h03);
    rd_chk("R11 beyond count", 4, 0, 0);
    ev(4'd1, 23'h000110, 0);
    chk("R11 idle no store", {25'd0, cnt}, 4);
  endtask

  task automatic t_order();
    do_arm();
    chk("R10 cnt cleared", {25'd0, cnt}, 0);
    chk("R10 done cleared", {31'd0, done}, 0);
    @(negedge clk);
    ev_v = 1; ev_c = 4'd2; ev_a = 23'h0A0000; ev_vec = 0;
    @(negedge clk);
    ev_c = 4'd4; ev_a = 23'h7FFFF0; ev_vec = 1;
    @(negedge clk);
    ev_v = 0; ev_vec = 0;
    stop();
    chk("R5 two lines", {25'd0, cnt}, 2);
    rd_chk("R5 dst first", 0, 23'h0A0000, 8'h01);
    rd_chk("R5 vector second", 1, 23'h7FFFF0, 8'h03);
  endtask

  task automatic t_end_trig();
    do_arm();
    ev(4'd1, 23'h000201, 0);
    cyc(0, 1, 1, 4'd1, 23'h000202, 0);
    chk("R7 trigger event dropped", {25'd0, cnt}, 1);
    chk("R7 disarmed", {31'd0, armed}, 0);
    rd_chk("R7 line kept", 0, 23'h000201, 8'h00);
    cyc(1, 0, 1, 4'd1, 23'h000203, 0);
    chk("R10 arm-cycle event dropped", {25'd0, cnt}, 0);
    stop();
  endtask

  task automatic t_wrap();
    do_arm();
    for (int i = 0; i < 70; i++) ev(4'd1, 23'(100 + i), 0);
    stop();
    chk("R6 cnt saturates", {25'd0, cnt}, 64);
    rd_chk("R6 oldest", 0, 23'd106, 8'h00);
    rd_chk("R6 newest", 63, 23'd169, 8'h00);
  endtask

  task automatic t_mid();
    policy = 1;
    do_arm();
    for (int i = 0; i < 5; i++) ev(4'd1, 23'(300 + i), 0);
    cyc(0, 1, 1, 4'd3, 23'd400, 0);
    chk("R8 trigger event stored", {25'd0, cnt}, 6);
    for (int i = 0; i < 31; i++) ev(4'd1, 23'(500 + i), 0);
    chk("R8 not done after 31", {31'd0, done}, 0);
    @(negedge clk);
    ev_v = 1; ev_c = 4'd1; ev_a = 23'd531;
    @(negedge clk);
    ev_v = 0;
    chk("R8 done after 32", {31'd0, done}, 1);
    chk("R8 brk raised", {31'd0, brk}, 1);
    chk("R8 disarmed", {31'd0, armed}, 0);
    @(negedge clk);
    chk("R8 brk one cycle", {31'd0, brk}, 0);
    ev(4'd1, 23'd600, 0);
    chk("R8 total lines", {25'd0, cnt}, 38);
    rd_chk("R8 trigger line", 5, 23'd400, 8'h01);
    rd_chk("R8 last line", 37, 23'd531, 8'h00);
    policy = 0;
  endtask

  task automatic t_mode();
    mode = 2'd2;
    do_arm();
    ev(4'd1, 23'h000700, 0);
    ev(4'd2, 23'h000701, 0);
    mode = 2'd3;
    ev(4'd3, 23'h000702, 0);
    stop();
    chk("R9 mode stub stores nothing", {25'd0, cnt}, 0);
    mode = 2'd0;
  endtask

  initial begin
    fork
      begin
        #10; rst_n = 1;
        @(negedge clk);
        t_reset();
        t_filter();
        t_order();
        t_end_trig();
        t_wrap();
        t_mid();
        t_mode();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule